// File: doc/BRIEF.md
# Search ROM Accelerator Datapath

This block speeds up the enumeration of devices on a one-wire bus. With search mode switched on, every byte the host writes carries four preferred path directions, one on each odd bit. The block then handles four consecutive ROM bit positions, lowest first. For each position it asks the bus engine for two read slots: first the bit, then its complement. It picks a direction, and it drives that direction back onto the bus in a third, write slot.

When the reads show a conflict, the direction comes from the host's preference for that position. After the fourth position it returns one byte. In that byte each chosen ROM bit sits on an odd position and a discrepancy flag for the same position sits on the even bit below it. A one-cycle done strobe marks the new result.

Sixteen such byte exchanges, lowest nibble first, cover a 64-bit ROM. If the last exchange returns both the chosen bit and the flag set at the top position, software treats the pass as a bus error. Picking the search path from one pass to the next is left to software.

Top module: `sra_accel`

## Requirements
- R1: After a synchronous active-low reset, `res_byte` is 0, `res_done` is 0, `slot_req` is 0 and `xfer_inhibit` is 0 while `mode_en` is 0.
- R2: A byte written while `mode_en` is 1 and the block is idle starts exactly 12 slot requests. They run in the order read, read, write, repeated four times, and each request is held until `slot_ack`. One cycle after the last acknowledge, `res_done` pulses for exactly one cycle.
- R3: For a read pair (a,b) of (0,1) the chosen bit is 0, and for (1,0) it is 1. In both cases the discrepancy flag is 0.
- R4: For (0,0) the flag is 1 and the chosen bit is the preference taken from input bit 2k+1 for step k. The even input bits (0, 2, 4, 6) have no effect.
- R5: For (1,1) both the flag and the chosen bit are 1.
- R6: Step k (k = 0..3, in that order) handles the k-th lowest ROM bit of the nibble. Its chosen bit appears at `res_byte` bit 2k+1 and its flag at bit 2k.
- R7: The write slot of each step has `slot_write` = 1 and `slot_wbit` equal to the chosen bit, and both stay stable until acknowledged. Read slots have `slot_write` = 0.
- R8: A byte written while `mode_en` is 0 is ignored. No slot is requested, no done pulse appears and `res_byte` keeps its value.
- R9: A byte written while a run is in progress is ignored. The run finishes with the preferences it started with and makes no extra slots.
- R10: Clearing `mode_en` during a run aborts it. `slot_req` is 0 from the next cycle, and no done pulse and no change of `res_byte` follow.
- R11: `xfer_inhibit` is 1 whenever `mode_en` is 1, which tells the normal byte transmit and receive path to stand aside.
- R12: `res_byte` changes only in the cycle in which `res_done` is 1, and it holds its value between results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_en | input | 1 | Search mode enable |
| wr_valid | input | 1 | One-cycle strobe: a byte was written to the data register |
| wr_byte | input | 8 | Written byte; odd bits are preferred directions |
| res_byte | output | 8 | Result: chosen bits on odd positions, flags on even |
| res_done | output | 1 | One-cycle strobe when a new result is in `res_byte` |
| xfer_inhibit | output | 1 | Suppresses normal byte transfers while the mode is on or a run is active |
| slot_req | output | 1 | Request for one bus time slot, held until acknowledged |
| slot_write | output | 1 | 1 = write slot, 0 = read slot |
| slot_wbit | output | 1 | Bit to drive in a write slot |
| slot_ack | input | 1 | One-cycle acknowledge that the requested slot completed |
| slot_rbit | input | 1 | Bit sampled in a read slot, valid with `slot_ack` |

## Verification
Two events can land on the same clock edge. A host write can arrive while a run is still stepping, and `mode_en` can fall in the very cycle the bus engine acknowledges a slot. The bench provokes the first by pulsing `wr_valid` with a conflicting byte partway through a run. It judges the result by the unchanged result byte and the slot count of exactly twelve. The second is provoked by dropping the mode during a run whose model acknowledges with fixed latency. There the bench requires that `slot_req` goes low, that no done pulse appears and that `res_byte` keeps its earlier value.

// File: rtl/sra_pkg.sv
// Shared types of the search accelerator datapath.
// Assumes: one-wire bit slots are timed by an external bus engine.
package sra_pkg;

    // Sequencer phase within one search step
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RD_A = 2'd1,
        ST_RD_B = 2'd2,
        ST_WR   = 2'd3
    } sra_state_e;

    // Outcome of one search step
    typedef struct packed {
        logic dir;       // chosen ROM bit / path direction
        logic conflict;  // discrepancy flag
    } step_res_t;

endpackage

// File: rtl/sra_step_decide.sv
// Picks the path direction for one ROM bit from the bit/complement pair.
// Assumes: rd_a is the bit slot, rd_b the complement slot; pure logic.
module sra_step_decide
    import sra_pkg::*;
(
    input  logic      rd_a,
    input  logic      rd_b,
    input  logic      pref,
    output step_res_t res
);

    // Decide direction and flag from the two reads
    always_comb begin
        unique case ({rd_a, rd_b})
            2'b01:   res = '{dir: 1'b0, conflict: 1'b0};
            2'b10:   res = '{dir: 1'b1, conflict: 1'b0};
            2'b00:   res = '{dir: pref, conflict: 1'b1};
            default: res = '{dir: 1'b1, conflict: 1'b1};
        endcase
    end

endmodule

// File: rtl/sra_seq.sv
// Slot sequencer: for each host byte runs STEPS steps of read, read, write.
// Assumes: slot_ack is a one-cycle pulse answering a held slot_req.
module sra_seq
    import sra_pkg::*;
#(
    parameter int STEPS = 4,
    localparam int IDX_W = (STEPS > 1) ? $clog2(STEPS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_en,
    input  logic             wr_valid,
    input  logic [STEPS-1:0] pref_in,
    input  logic             slot_ack,
    input  logic             slot_rbit,
    input  logic             step_dir,
    output logic             slot_req,
    output logic             slot_write,
    output logic             slot_wbit,
    output logic             bit_a,
    output logic             bit_b,
    output logic             pref_sel,
    output logic [IDX_W-1:0] step_idx,
    output logic             commit,
    output logic             last,
    output logic             busy
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(STEPS - 1);

    sra_state_e       state_q;
    logic [STEPS-1:0] pref_q;

    // Phase, step counter and captured reads
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            step_idx <= '0;
            pref_q   <= '0;
            bit_a    <= 1'b0;
            bit_b    <= 1'b0;
        end else if (!mode_en) begin
            state_q <= ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: if (wr_valid) begin
                    pref_q   <= pref_in;
                    step_idx <= '0;
                    state_q  <= ST_RD_A;
                end
                ST_RD_A: if (slot_ack) begin
                    bit_a   <= slot_rbit;
                    state_q <= ST_RD_B;
                end
                ST_RD_B: if (slot_ack) begin
                    bit_b   <= slot_rbit;
                    state_q <= ST_WR;
                end
                default: if (slot_ack) begin
                    if (step_idx == LAST_IDX) begin
                        state_q <= ST_IDLE;
                    end else begin
                        step_idx <= step_idx + 1'b1;
                        state_q  <= ST_RD_A;
                    end
                end
            endcase
        end
    end

    // Slot request fields and step completion strobes
    always_comb begin
        busy       = (state_q != ST_IDLE);
        slot_req   = busy;
        slot_write = (state_q == ST_WR);
        slot_wbit  = slot_write & step_dir;
        pref_sel   = pref_q[step_idx];
        commit     = (state_q == ST_WR) && slot_ack && mode_en;
        last       = commit && (step_idx == LAST_IDX);
    end

    // R2
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_req && !slot_ack && mode_en) |=> slot_req);

    // R7
    wr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_req && !slot_ack && mode_en) |=> ($stable(slot_write) && $stable(slot_wbit)));

    // R10
    abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_en |=> !slot_req);

    // R6
    step_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && !last) |=> (step_idx == $past(step_idx) + 1'b1));

endmodule

// File: rtl/sra_result_pack.sv
// Collects per-step outcomes and interleaves them into the result byte.
// Assumes: one commit per step, steps in ascending index, last marks the final one.
module sra_result_pack
    import sra_pkg::*;
#(
    parameter int STEPS = 4,
    localparam int IDX_W = (STEPS > 1) ? $clog2(STEPS) : 1,
    localparam int BYTE_W = 2 * STEPS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit,
    input  logic              last,
    input  logic [IDX_W-1:0]  step_idx,
    input  step_res_t         res,
    output logic [BYTE_W-1:0] res_byte,
    output logic              res_done
);

    logic [STEPS-1:0]  dir_q;
    logic [STEPS-1:0]  flag_q;
    logic [BYTE_W-1:0] merged;

    // Interleave stored outcomes, substituting the step being committed
    for (genvar k = 0; k < STEPS; k++) begin : g_lane
        logic hit;
        assign hit           = (step_idx == IDX_W'(k));
        assign merged[2*k+1] = hit ? res.dir      : dir_q[k];
        assign merged[2*k]   = hit ? res.conflict : flag_q[k];
    end

    // Per-step storage, result register and done strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q    <= '0;
            flag_q   <= '0;
            res_byte <= '0;
            res_done <= 1'b0;
        end else begin
            res_done <= last;
            if (commit) begin
                dir_q[step_idx]  <= res.dir;
                flag_q[step_idx] <= res.conflict;
            end
            if (last) begin
                res_byte <= merged;
            end
        end
    end

    // R2
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_done |=> !res_done);

    // R12
    res_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(res_byte) |-> res_done);

endmodule

// File: rtl/sra_accel.sv
// Search ROM accelerator datapath top: host byte in, interleaved result out,
// slot requests to the one-wire bus engine.
// Assumes: the bus engine answers every slot_req with a single-cycle slot_ack.
module sra_accel
    import sra_pkg::*;
#(
    parameter int STEPS = 4,
    localparam int IDX_W = (STEPS > 1) ? $clog2(STEPS) : 1,
    localparam int BYTE_W = 2 * STEPS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_en,
    input  logic              wr_valid,
    input  logic [BYTE_W-1:0] wr_byte,
    output logic [BYTE_W-1:0] res_byte,
    output logic              res_done,
    output logic              xfer_inhibit,
    output logic              slot_req,
    output logic              slot_write,
    output logic              slot_wbit,
    input  logic              slot_ack,
    input  logic              slot_rbit
);

    logic [STEPS-1:0] pref_in;
    logic             bit_a;
    logic             bit_b;
    logic             pref_sel;
    logic [IDX_W-1:0] step_idx;
    logic             commit;
    logic             last;
    logic             busy;
    step_res_t        step_res;

    // Preferred directions live on the odd bits of the written byte
    for (genvar k = 0; k < STEPS; k++) begin : g_pref
        assign pref_in[k] = wr_byte[2*k+1];
    end

    // Normal transfers stand aside while searching
    always_comb xfer_inhibit = mode_en | busy;

    sra_seq #(.STEPS(STEPS)) seq_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_en    (mode_en),
        .wr_valid   (wr_valid),
        .pref_in    (pref_in),
        .slot_ack   (slot_ack),
        .slot_rbit  (slot_rbit),
        .step_dir   (step_res.dir),
        .slot_req   (slot_req),
        .slot_write (slot_write),
        .slot_wbit  (slot_wbit),
        .bit_a      (bit_a),
        .bit_b      (bit_b),
        .pref_sel   (pref_sel),
        .step_idx   (step_idx),
        .commit     (commit),
        .last       (last),
        .busy       (busy)
    );

    sra_step_decide decide_i (
        .rd_a (bit_a),
        .rd_b (bit_b),
        .pref (pref_sel),
        .res  (step_res)
    );

    sra_result_pack #(.STEPS(STEPS)) pack_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .commit   (commit),
        .last     (last),
        .step_idx (step_idx),
        .res      (step_res),
        .res_byte (res_byte),
        .res_done (res_done)
    );

    // R11
    inhibit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_en |-> xfer_inhibit);

    // R8
    idle_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !mode_en) |=> !busy);

endmodule

// File: tb/sra_accel_tb.sv
module sra_accel_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_en = 1'b0;
    logic       wr_valid = 1'b0;
    logic [7:0] wr_byte = 8'h00;
    logic [7:0] res_byte;
    logic       res_done;
    logic       xfer_inhibit;
    logic       slot_req;
    logic       slot_write;
    logic       slot_wbit;
    logic       slot_ack = 1'b0;
    logic       slot_rbit = 1'b0;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    // bus model state
    logic [7:0]  ab_cur = 8'h00;
    int          rcount = 0;
    int          wcount = 0;
    int          slot_n = 0;
    int          lat = 0;
    int          done_cnt = 0;
    logic [15:0] kind_log = '0;
    logic [3:0]  wlog = '0;

    // {wr_byte, read pairs (step k: a=bit 2k+1, b=bit 2k), expected result, expected write bits}
    localparam logic [27:0] VEC [7] = '{
        {8'h00, 8'h55, 8'h00, 4'b0000},   // R3 all (0,1)
        {8'h00, 8'hAA, 8'hAA, 4'b1111},   // R3 all (1,0)
        {8'hAA, 8'h00, 8'hFF, 4'b1111},   // R4 conflicts, prefer 1
        {8'h55, 8'h00, 8'h55, 4'b0000},   // R4 conflicts, even bits ignored
        {8'h00, 8'hFF, 8'hFF, 4'b1111},   // R5 no device, top bit error
        {8'h08, 8'hE1, 8'hEC, 4'b1110},   // R6 mixed order
        {8'h02, 8'h10, 8'h47, 4'b0001}    // R6 mixed order
    };

    sra_accel dut_i (
        .clk(clk), .rst_n(rst_n), .mode_en(mode_en), .wr_valid(wr_valid),
        .wr_byte(wr_byte), .res_byte(res_byte), .res_done(res_done),
        .xfer_inhibit(xfer_inhibit), .slot_req(slot_req), .slot_write(slot_write),
        .slot_wbit(slot_wbit), .slot_ack(slot_ack), .slot_rbit(slot_rbit)
    );

    always #10 clk = ~clk;

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // bus engine model: fixed-latency single-cycle acknowledge
    always @(negedge clk) begin
        if (res_done) done_cnt++;
        if (slot_ack) begin
            slot_ack = 1'b0;
            lat = 0;
        end else if (slot_req) begin
            if (lat == 2) begin
                slot_ack = 1'b1;
                lat = 0;
                if (slot_n < 16) kind_log[slot_n] = slot_write;
                slot_n++;
                if (!slot_write) begin
                    slot_rbit = rcount[0] ? ab_cur[2*(rcount>>1)] : ab_cur[2*(rcount>>1)+1];
                    rcount++;
                end else begin
                    wlog[wcount[1:0]] = slot_wbit;
                    wcount++;
                end
            end else begin
                lat++;
            end
        end else begin
            lat = 0;
        end
    end

    // watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic prep(input logic [7:0] ab);
        ab_cur = ab; rcount = 0; wcount = 0; slot_n = 0; kind_log = '0; wlog = '0;
    endtask

    task automatic send(input logic [7:0] b);
        @(negedge clk); wr_valid = 1'b1; wr_byte = b;
        @(negedge clk); wr_valid = 1'b0;
    endtask

    task automatic wait_done(input int start);
        for (int i = 0; i < 300 && done_cnt == start; i++) @(negedge clk);
    endtask

    initial begin
        int d0;
        logic [7:0] held;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(res_byte == 8'h00, "R1 res_byte", res_byte, 0);
        check(res_done == 1'b0, "R1 res_done", res_done, 0);
        check(slot_req == 1'b0, "R1 slot_req", slot_req, 0);
        check(xfer_inhibit == 1'b0, "R1 xfer_inhibit", xfer_inhibit, 0);
        rst_n = 1'b1;
        @(negedge clk);
        mode_en = 1'b1;
        @(negedge clk);
        check(xfer_inhibit == 1'b1, "R11 inhibit with mode", xfer_inhibit, 1);

        // vector table walk
        for (int v = 0; v < 7; v++) begin
            prep(VEC[v][19:12]);
            d0 = done_cnt;
            send(VEC[v][27:20]);
            wait_done(d0);
            check(res_byte == VEC[v][11:4], "R3 R4 R5 R6 result", res_byte, VEC[v][11:4]);
            check(wlog == VEC[v][3:0], "R7 written bits", wlog, VEC[v][3:0]);
            check(slot_n == 12 && kind_log[11:0] == 12'h924, "R2 slot order",
                  {slot_n[15:0], kind_log}, {16'd12, 16'h0924});
            repeat (4) @(negedge clk);
            check(done_cnt == d0 + 1, "R2 single done", done_cnt, d0 + 1);
            check(res_byte == VEC[v][11:4], "R12 result held", res_byte, VEC[v][11:4]);
        end

        // R9: byte during a run is ignored
        prep(8'hE1);
        d0 = done_cnt;
        send(8'h08);
        repeat (5) @(negedge clk);
        send(8'hFF);
        wait_done(d0);
        check(res_byte == 8'hEC, "R9 busy write ignored", res_byte, 8'hEC);
        repeat (4) @(negedge clk);
        check(slot_n == 12, "R9 no extra slots", slot_n, 12);

        // R8: write with mode off is ignored
        mode_en = 1'b0;
        @(negedge clk);
        check(xfer_inhibit == 1'b0, "R11 inhibit off", xfer_inhibit, 0);
        prep(8'h00);
        d0 = done_cnt;
        send(8'hAA);
        repeat (30) @(negedge clk);
        check(slot_n == 0, "R8 no slots", slot_n, 0);
        check(done_cnt == d0, "R8 no done", done_cnt, d0);
        check(res_byte == 8'hEC, "R8 result kept", res_byte, 8'hEC);

        // R10: abort mid run, dropped on an acknowledge edge
        mode_en = 1'b1;
        prep(8'hFF);
        d0 = done_cnt;
        held = res_byte;
        send(8'h00);
        for (int i = 0; i < 100 && !(slot_ack && slot_n == 5); i++) @(negedge clk);
        mode_en = 1'b0;
        @(negedge clk);
        check(slot_req == 1'b0, "R10 req dropped", slot_req, 0);
        repeat (20) @(negedge clk);
        check(done_cnt == d0, "R10 no done", done_cnt, d0);
        check(res_byte == held, "R10 result kept", res_byte, held);

        // recovery after abort
        mode_en = 1'b1;
        prep(8'h10);
        d0 = done_cnt;
        send(8'h02);
        wait_done(d0);
        check(res_byte == 8'h47, "R6 run after abort", res_byte, 8'h47);
        check(slot_n == 12, "R2 slots after abort", slot_n, 12);

        // R1: reset mid-operation restores reset state
        rst_n = 1'b0;
        mode_en = 1'b0;
        repeat (2) @(negedge clk);
        check(res_byte == 8'h00 && res_done == 1'b0 && slot_req == 1'b0, "R1 re-reset",
              {res_byte, res_done, slot_req}, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule